// File: doc/BRIEF.md
# Page Protection and Reference/Change Unit

This block receives one leaf page-table entry at a time, together with the address the entry was read from and the context of the access that needs it. It decides whether the access is allowed and which read/write/execute rights the translation may keep. When the access is allowed, it also produces the updated entry, with the reference bit set and, for stores, the change bit set. That updated entry goes back to memory through a single write request with a valid/ready handshake.

The unit sits after the table walker, which fetches the entry, and before the exception logic, which records any fault. Change tracking is lazy. A load or fetch never gets write permission back. A later store therefore has to come through the unit again, and that visit marks the page as changed.

Top module: `pte_guard_rc`

## Requirements
- R1: An instruction fetch (access code 2'b10) whose entry has attribute bits [5:4] equal to 2'b10 (non-idempotent I/O) faults with only the guard cause bit (cause bit 0) set, whatever the authority bits say.
- R2: For a process-scoped access (partition flag low) in problem state, an entry with its privileged bit (bit 3) set grants nothing, so every access type faults.
- R3: When the translation index belongs to problem state, or the entry is privileged, or the access is partition-scoped, the rights come from the entry alone and the mask input has no effect.
- R4: In every other case, the entry's rights are ANDed with the 3-bit authority mask (bit 0 read, bit 1 write, bit 2 execute).
- R5: The rights are decoded from the entry's low bits and use the same bit order as the mask. Bit 2 gives read. Bit 1 gives read and write. Bit 0 gives execute.
- R6: Access codes are 2'b00 load (needs read), 2'b01 store (needs write) and 2'b10 fetch (needs execute). If the needed right is missing, a fetch reports cause bit 0 and a data access reports cause bit 1. A faulting access returns an empty grant and makes no write.
- R7: On a successful access the updated entry has the reference bit (bit 8) set. The change bit (bit 7) is set only for a store and is otherwise left as it was.
- R8: A successful load or fetch never returns write permission in the grant.
- R9: A write request is raised only if the updated entry differs from the input entry. Otherwise the access completes without one.
- R10: The write request keeps its address and data stable until ready is seen. `done` is a one-cycle pulse: it comes two cycles after the request when no write is needed, and one cycle after the write handshake otherwise.
- R11: A request that arrives while `busy` is high is ignored and produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a check; taken only while idle |
| req_pte | input | PTE_W | Leaf entry to check |
| req_addr | input | ADDR_W | Memory address of the entry |
| req_acc | input | 2 | Access code: load, store or fetch |
| req_prob | input | 1 | Processor is in problem state |
| req_part | input | 1 | Access is partition-scoped |
| req_idx_user | input | 1 | Translation index belongs to problem state |
| req_amr | input | 3 | Authority mask rights {x,w,r} |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse; result valid |
| grant | output | 3 | Granted rights {x,w,r} |
| fault | output | 1 | Access denied |
| cause | output | 2 | Fault cause: bit 0 guard/no-exec, bit 1 protection |
| wr_valid | output | 1 | Entry write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Updated entry |

## Verification
The assertions assume that the memory side never drops `wr_ready` in a way that matters to the unit. They also assume that the access code is never the reserved value 2'b11, which is treated as a load. The checks on held data assume that a write stays open until ready is seen. The bench uses only the three defined access codes and drives ready from a stall count that rises to 1 and stays there while `wr_valid` is high. It also sends one extra request while the unit is busy, so that the unit is shown to ignore it.

// File: rtl/pte_guard_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the page protection unit: access codes, entry bit
// positions, right and cause bit indices, and control states.
package pte_guard_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    localparam int EAA_X    = 0;
    localparam int EAA_RW   = 1;
    localparam int EAA_RD   = 2;
    localparam int EAA_PRIV = 3;
    localparam int ATT_LO   = 4;
    localparam int CHG_BIT  = 7;
    localparam int REF_BIT  = 8;
    localparam logic [1:0] ATT_NIO = 2'b10;

    localparam int P_RD = 0;
    localparam int P_WR = 1;
    localparam int P_EX = 2;

    localparam int CAUSE_GUARD = 0;
    localparam int CAUSE_PROT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CHECK = 2'b01,
        ST_WRITE = 2'b10,
        ST_DONE  = 2'b11
    } st_e;
endpackage

// File: rtl/pte_perm_eval.sv
`timescale 1ns/1ps
// Combinational rights evaluation. Takes the authority and attribute bits of
// a leaf entry plus the access context. Returns the granted rights and a
// fault with its cause. Assumes the access code is one of the three defined
// values; the reserved code is treated as a load.
module pte_perm_eval
    import pte_guard_pkg::*;
(
    input  logic [3:0] eaa,
    input  logic [1:0] att,
    input  logic [1:0] acc,
    input  logic       in_prob,
    input  logic       part,
    input  logic       idx_user,
    input  logic [2:0] amr,
    output logic [2:0] perm,
    output logic       fault,
    output logic [1:0] cause
);
    logic [2:0] eaa_perm;
    logic [2:0] eff_perm;
    logic [2:0] need;
    logic       nio_fetch;

    // Decode the entry's own rights and pick the privilege rule that applies.
    always_comb begin
        eaa_perm        = '0;
        eaa_perm[P_RD]  = eaa[EAA_RD] | eaa[EAA_RW];
        eaa_perm[P_WR]  = eaa[EAA_RW];
        eaa_perm[P_EX]  = eaa[EAA_X];
        if (!part && eaa[EAA_PRIV] && in_prob)
            eff_perm = '0;
        else if (idx_user || eaa[EAA_PRIV] || part)
            eff_perm = eaa_perm;
        else
            eff_perm = eaa_perm & amr;
    end

    // Work out the right the access needs.
    always_comb begin
        need = '0;
        case (acc)
            ACC_STORE: need[P_WR] = 1'b1;
            ACC_FETCH: need[P_EX] = 1'b1;
            default:   need[P_RD] = 1'b1;
        endcase
    end

    // Resolve the fault: the I/O fetch check comes first, then missing rights.
    always_comb begin
        nio_fetch = (att == ATT_NIO) && (acc == ACC_FETCH);
        perm  = eff_perm;
        fault = 1'b0;
        cause = '0;
        if (nio_fetch) begin
            fault              = 1'b1;
            cause[CAUSE_GUARD] = 1'b1;
            perm               = '0;
        end else if ((need & ~eff_perm) != 3'b000) begin
            fault = 1'b1;
            perm  = '0;
            if (acc == ACC_FETCH)
                cause[CAUSE_GUARD] = 1'b1;
            else
                cause[CAUSE_PROT] = 1'b1;
        end
    end
endmodule

// File: rtl/pte_rc_merge.sv
`timescale 1ns/1ps
// Combinational reference/change update. Sets the reference bit, sets the
// change bit for stores, flags whether the entry changed, and removes write
// permission for non-store accesses. Assumes the caller ignores the result
// when the access faulted.
module pte_rc_merge
    import pte_guard_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic [1:0]       acc,
    input  logic [2:0]       perm_in,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed,
    output logic [2:0]       perm_out
);
    // Build the updated entry and the trimmed rights.
    always_comb begin
        pte_out          = pte_in;
        pte_out[REF_BIT] = 1'b1;
        perm_out         = perm_in;
        if (acc == ACC_STORE)
            pte_out[CHG_BIT] = 1'b1;
        else
            perm_out[P_WR] = 1'b0;
        changed = (pte_out != pte_in);
    end
endmodule

// File: rtl/pte_guard_rc.sv
`timescale 1ns/1ps
// Page protection and reference/change unit (top). Takes one leaf entry
// while idle, checks its rights in the next cycle, and, if the entry must be
// updated, holds one write request until it is accepted. Then it pulses done
// with the registered result. Assumes the entry width covers the reference
// bit.
module pte_guard_rc
    import pte_guard_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PTE_W-1:0]  req_pte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_acc,
    input  logic              req_prob,
    input  logic              req_part,
    input  logic              req_idx_user,
    input  logic [2:0]        req_amr,
    output logic              busy,
    output logic              done,
    output logic [2:0]        grant,
    output logic              fault,
    output logic [1:0]        cause,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTE_W-1:0]  wr_data
);
    localparam int MIN_W = REF_BIT + 1;

    st_e               state;
    logic [PTE_W-1:0]  pte_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        acc_q;
    logic              prob_q, part_q, idxu_q;
    logic [2:0]        amr_q;

    logic [2:0]        ev_perm;
    logic              ev_fault;
    logic [1:0]        ev_cause;
    logic [PTE_W-1:0]  rc_pte;
    logic              rc_changed;
    logic [2:0]        rc_perm;

    // Elaboration guard: the entry must hold the reference bit.
    if (PTE_W < MIN_W) begin : g_width_bad
        initial $fatal(1, "PTE_W too small");
    end

    pte_perm_eval i_eval (
        .eaa      (pte_q[EAA_PRIV:EAA_X]),
        .att      (pte_q[ATT_LO+1:ATT_LO]),
        .acc      (acc_q),
        .in_prob  (prob_q),
        .part     (part_q),
        .idx_user (idxu_q),
        .amr      (amr_q),
        .perm     (ev_perm),
        .fault    (ev_fault),
        .cause    (ev_cause)
    );

    pte_rc_merge #(.PTE_W(PTE_W)) i_rc (
        .pte_in   (pte_q),
        .acc      (acc_q),
        .perm_in  (ev_perm),
        .pte_out  (rc_pte),
        .changed  (rc_changed),
        .perm_out (rc_perm)
    );

    // Capture the request while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_q  <= '0;
            addr_q <= '0;
            acc_q  <= '0;
            prob_q <= 1'b0;
            part_q <= 1'b0;
            idxu_q <= 1'b0;
            amr_q  <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            pte_q  <= req_pte;
            addr_q <= req_addr;
            acc_q  <= req_acc;
            prob_q <= req_prob;
            part_q <= req_part;
            idxu_q <= req_idx_user;
            amr_q  <= req_amr;
        end
    end

    // Sequence: idle, check, optional write, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (req_valid) state <= ST_CHECK;
                ST_CHECK: state <= (!ev_fault && rc_changed) ? ST_WRITE : ST_DONE;
                ST_WRITE: if (wr_ready) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Register the result and the updated entry at the end of the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant   <= '0;
            fault   <= 1'b0;
            cause   <= '0;
            wr_data <= '0;
        end else if (state == ST_CHECK) begin
            fault   <= ev_fault;
            cause   <= ev_cause;
            grant   <= ev_fault ? 3'b000 : rc_perm;
            wr_data <= rc_pte;
        end
    end

    // Drive the handshake and status outputs from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        wr_valid = (state == ST_WRITE);
        wr_addr  = addr_q;
    end
endmodule

// File: rtl/pte_guard_rc_chk.sv
`timescale 1ns/1ps
// Checker for pte_guard_rc, attached by bind. Observes the ports and the
// captured entry and access code. Assumes wr_ready is never X while
// wr_valid is high.
module pte_guard_rc_chk
    import pte_guard_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fault,
    input logic [1:0]        cause,
    input logic [2:0]        grant,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PTE_W-1:0]  wr_data,
    input logic [PTE_W-1:0]  pte_q,
    input logic [1:0]        acc_q
);
    assert_nio_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done && acc_q == ACC_FETCH && pte_q[ATT_LO+1:ATT_LO] == ATT_NIO
        |-> fault && cause == 2'b01);

    assert_fault_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> grant == 3'b000 && $countones(cause) == 1);

    assert_no_write_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !fault);

    assert_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[REF_BIT]);

    assert_chg_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && acc_q != ACC_STORE |-> wr_data[CHG_BIT] == pte_q[CHG_BIT]);

    assert_no_wr_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault && acc_q != ACC_STORE |-> !grant[P_WR]);

    assert_write_changed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data != pte_q);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind pte_guard_rc pte_guard_rc_chk #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .fault    (fault),
    .cause    (cause),
    .grant    (grant),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pte_q    (pte_q),
    .acc_q    (acc_q)
);

// File: tb/test_pte_guard_rc.sv
`timescale 1ns/1ps
// Scoreboard bench: send() queues the expected result; the monitor compares
// each done pulse and any write seen before it.
module test_pte_guard_rc;
    localparam int PW = 64;
    localparam int AW = 64;
    localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10;
    localparam logic [63:0] BASE = 64'hC000_0000_1234_5000;
    localparam logic [63:0] REFB = 64'h100, CHGB = 64'h80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [PW-1:0] req_pte = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_acc = '0;
    logic req_prob = 1'b0, req_part = 1'b0, req_idx_user = 1'b0;
    logic [2:0] req_amr = '0;
    logic busy, done, fault, wr_valid;
    logic wr_ready = 1'b0;
    logic [2:0] grant;
    logic [1:0] cause;
    logic [AW-1:0] wr_addr;
    logic [PW-1:0] wr_data;

    typedef struct {
        logic [2:0] grant; logic fault; logic [1:0] cause;
        bit wr; logic [63:0] addr; logic [63:0] data; string tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0, stall_cfg = 0, dones = 0, sent = 0;
    bit saw_wr = 0;
    logic [63:0] seen_addr, seen_data;

    always #2 clk = ~clk;

    pte_guard_rc #(.PTE_W(PW), .ADDR_W(AW)) i_pte_guard_rc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
        .req_addr(req_addr), .req_acc(req_acc), .req_prob(req_prob),
        .req_part(req_part), .req_idx_user(req_idx_user), .req_amr(req_amr),
        .busy(busy), .done(done), .grant(grant), .fault(fault), .cause(cause),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

    function automatic exp_t model(input logic [63:0] pte, input logic [63:0] addr,
        input logic [1:0] acc, input bit prob, input bit part, input bit idxu,
        input logic [2:0] amr, input string tag);
        exp_t e;
        logic [2:0] p, need;
        logic [63:0] np;
        e.tag = tag; e.addr = addr; e.wr = 0; e.data = '0;
        e.fault = 0; e.cause = 2'b00; e.grant = 3'b000;
        if (pte[5:4] == 2'b10 && acc == FE) begin
            e.fault = 1; e.cause = 2'b01; return e;
        end
        p = {pte[0], pte[1], pte[2] | pte[1]};
        if (!part && pte[3] && prob) p = 3'b000;
        else if (!(idxu || pte[3] || part)) p = p & amr;
        need = (acc == ST) ? 3'b010 : (acc == FE) ? 3'b100 : 3'b001;
        if ((need & ~p) != 0) begin
            e.fault = 1; e.cause = (acc == FE) ? 2'b01 : 2'b10; return e;
        end
        np = pte | REFB | ((acc == ST) ? CHGB : 64'h0);
        e.grant = (acc == ST) ? p : (p & 3'b101);
        e.wr = (np != pte); e.data = np;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] pte, input logic [63:0] addr,
        input logic [1:0] acc, input bit prob, input bit part, input bit idxu,
        input logic [2:0] amr, input int stall, input string tag);
        while (busy) @(negedge clk);
        stall_cfg = stall;
        q.push_back(model(pte, addr, acc, prob, part, idxu, amr, tag));
        sent++;
        req_valid = 1; req_pte = pte; req_addr = addr; req_acc = acc;
        req_prob = prob; req_part = part; req_idx_user = idxu; req_amr = amr;
        @(negedge clk);
        req_valid = 0;
        while (q.size() > 0) @(negedge clk);
    endtask

    // Ready driver: raises ready after stall_cfg cycles of an open request.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(posedge clk); #1;
            if (wr_valid) begin
                wr_ready = (cnt >= stall_cfg);
                cnt++;
            end else begin
                wr_ready = 0; cnt = 0;
            end
        end
    end

    // Monitor: records writes and compares each completion with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_valid && wr_ready) begin
                saw_wr = 1; seen_addr = wr_addr; seen_data = wr_data;
            end
            if (rst_n && done) begin
                dones++;
                if (q.size() == 0) begin
                    check(0, "R11", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(grant == e.grant, e.tag, "grant", 64'(grant), 64'(e.grant));
                    check(fault == e.fault && cause == e.cause, e.tag, "fault/cause",
                          64'({fault, cause}), 64'({e.fault, e.cause}));
                    check(saw_wr == e.wr, e.tag, "write presence", 64'(saw_wr), 64'(e.wr));
                    if (e.wr && saw_wr)
                        check(seen_data == e.data && seen_addr == e.addr, e.tag,
                              "write data", seen_data, e.data);
                end
                saw_wr = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !wr_valid, "R10", "reset outputs",
              64'({busy, done, wr_valid}), 64'd0);

        send(BASE | 64'h27, 64'h1000, FE, 0, 0, 0, 3'b111, 0, "R1 nio fetch");
        send(BASE | 64'h27, 64'h1008, LD, 0, 0, 0, 3'b111, 0, "R1 nio load ok");
        send(BASE | 64'h0C, 64'h1010, LD, 1, 0, 1, 3'b111, 0, "R2 priv in problem state");
        send(BASE | 64'h0C, 64'h1018, LD, 1, 1, 1, 3'b000, 0, "R3 partition scoped");
        send(BASE | 64'h02, 64'h1020, ST, 1, 0, 1, 3'b000, 0, "R3 user index store");
        send(BASE | 64'h0C, 64'h1028, LD, 0, 0, 0, 3'b000, 0, "R3 priv entry ignores mask");
        send(BASE | 64'h07, 64'h1030, ST, 0, 0, 0, 3'b001, 0, "R4 R6 mask blocks store");
        send(BASE | 64'h07, 64'h1038, LD, 0, 0, 0, 3'b001, 0, "R4 R8 mask read only");
        send(BASE | 64'h07, 64'h1040, FE, 0, 0, 0, 3'b101, 0, "R5 R8 fetch");
        send(BASE | 64'h06, 64'h1048, FE, 0, 0, 0, 3'b111, 0, "R6 no exec");
        send(BASE | 64'h07 | REFB | CHGB, 64'h1050, ST, 0, 0, 0, 3'b111, 0, "R9 R7 no change");
        send(BASE | 64'h03 | REFB, 64'h1058, LD, 0, 0, 1, 3'b000, 0, "R9 R8 ref already set");
        send(BASE | 64'h02, 64'h1060, ST, 0, 0, 1, 3'b000, 3, "R10 R7 stalled write");

        // R11: a second request while busy must be dropped.
        while (busy) @(negedge clk);
        stall_cfg = 4;
        q.push_back(model(BASE | 64'h02, 64'h2000, ST, 0, 0, 1, 3'b000, "R11 first"));
        sent++;
        req_valid = 1; req_pte = BASE | 64'h02; req_addr = 64'h2000; req_acc = ST;
        req_prob = 0; req_part = 0; req_idx_user = 1; req_amr = 3'b000;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        req_valid = 1; req_pte = BASE | 64'h06; req_addr = 64'h3000; req_acc = LD;
        @(negedge clk);
        req_valid = 0;
        while (q.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
        check(!busy && dones == sent, "R11", "completions vs requests",
              64'(dones), 64'(sent));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule